// File: doc/BRIEF.md
# I2C Bit Clock Timer

This block times the clock and data edges of one I2C bit for a bus master. A sequencer asks it for a bit with a one-cycle request and the bit value. The block pulls SCL low and waits a programmed hold delay before it moves SDA. It then waits a programmed setup delay and the programmed low count before it releases SCL. The sequencer builds START, STOP, address and data bytes out of these bits.

All delays are counted in prescaled units of `presc+1` kernel clocks. Once SCL is released, the block waits until a two-stage synchronizer shows the line high, so a slave that holds SCL low stretches the bit. The block then counts the high period. It pulses `bit_sample` when SCL is first seen high, which is where the sequencer reads SDA. It pulses `bit_done` when it pulls SCL low again. If another master pulls SCL low during the high count, the bit ends at once and the next bit's low count starts from that fall. Between bits, SCL stays low and SDA keeps its last value.

Top module: `scl_bit_timer`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `bit_sample` and `bit_done` are all 0, so both lines are released.
- R2: The time unit is `presc+1` kernel clocks. Each of the delays in R3, R4 and R6 scales by that factor for every `presc` value from 0 to 15.
- R3: Let A be the rising edge that accepts a request. `sda_oe` takes the value `!bit_val` (1 pulls SDA low, encoding a 0) on rising edge A + `hold_dly*(presc+1)+1`. If the value does not change, there is no edge on SDA.
- R4: `scl_oe` returns to 0 on rising edge A + `max(low_cnt+1, hold_dly+setup_dly+1)*(presc+1)+1`. The SCL low time therefore covers both the low count and a setup of `setup_dly+1` units after the SDA update.
- R5: `bit_sample` pulses 3 kernel clocks after the SCL line is first high following the release. A slave that holds SCL low delays it by exactly the length of the hold.
- R6: When the line stays high, `bit_done` pulses `(high_cnt+1)*(presc+1)+1` kernel clocks after `bit_sample`. `scl_oe` goes to 1 in the same cycle.
- R7: If the SCL line goes low during the high count, `bit_done` pulses and `scl_oe` goes to 1 three kernel clocks later, ending the bit early.
- R8: A request that arrives while a bit is in progress is ignored. It changes neither the timing of that bit nor starts another.
- R9: After `bit_done` and without a new request, `scl_oe` stays 1 and `sda_oe` keeps its value.
- R10: `sda_oe` does not change while `scl_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 4 | Prescaler; one unit is presc+1 clocks |
| low_cnt | input | 8 | SCL low count, low_cnt+1 units |
| high_cnt | input | 8 | SCL high count, high_cnt+1 units |
| hold_dly | input | 4 | Units from SCL low to SDA update |
| setup_dly | input | 4 | Setup of setup_dly+1 units from SDA update to SCL release |
| bit_req | input | 1 | One-cycle request for a bit, taken when idle |
| bit_val | input | 1 | Value of the requested bit |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bit_sample | output | 1 | Pulse where SCL is first seen high |
| bit_done | output | 1 | Pulse where SCL is pulled low to end the bit |

## Verification
Bits are sent under several timing mixes, and each mix separates one cause from another:
- A long low count against a long hold-plus-setup shows which of the two sets the release time.
- Prescaler values of 0, 1, 2, 3 and 15 show that every delay is scaled by the prescaler and not by one fixed divider.
- Repeated bit values check that SDA stays quiet when it does not need to change.
- A bench-held low on SCL after release tells a stretched bit apart from a normal one.
- Another master pulling SCL low partway through the high count tells an early end from the counted one.
- A second request sent while a bit is in progress shows that it is dropped.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_tmr_sync.sv
module scl_tmr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  // stage 0 takes the input, each further stage takes the one before
  assign sh_d[0] = d;
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    assign sh_d[g] = sh_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scl_tmr_presc.sv
module scl_tmr_presc #(
  parameter int PRESC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q, cnt_d;
  logic               wrap;

  assign wrap = (cnt_q >= presc);
  assign tick = wrap && !restart;

  always_comb begin
    if (restart || wrap) cnt_d = '0;
    else                 cnt_d = cnt_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: every unit boundary starts a fresh unit of presc+1 clocks
  p_unit_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/scl_tmr_ucnt.sv
module scl_tmr_ucnt #(
  parameter int UW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  output logic [UW-1:0] units
);
  logic [UW-1:0] units_q, units_d;
  logic          units_en;

  assign units_en = clear || (tick && (units_q != {UW{1'b1}}));

  always_comb begin
    if (clear) units_d = '0;
    else       units_d = units_q + UW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        units_q <= '0;
    else if (units_en) units_q <= units_d;
  end

  assign units = units_q;

  // R2: units only advance on a prescaler tick
  p_units_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(units_q));
endmodule

// File: rtl/scl_bit_timer.sv
module scl_bit_timer
  import scl_tmr_pkg::*;
#(
  parameter int PRESC_W     = 4,
  parameter int CNT_W       = 8,
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [CNT_W-1:0]   low_cnt,
  input  logic [CNT_W-1:0]   high_cnt,
  input  logic [DLY_W-1:0]   hold_dly,
  input  logic [DLY_W-1:0]   setup_dly,
  input  logic               bit_req,
  input  logic               bit_val,
  input  logic               scl_in,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               bit_sample,
  output logic               bit_done
);
  localparam int UW = ((CNT_W > DLY_W + 1) ? CNT_W : DLY_W + 1) + 1;

  logic          rst_s_n;
  logic          scl_s;
  logic          tick;
  logic          restart;
  logic [UW-1:0] units;

  // reset: asserted at once, released on a clock edge
  scl_tmr_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  scl_tmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_s_n), .d(scl_in), .q(scl_s)
  );

  scl_tmr_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_s_n), .restart(restart), .presc(presc), .tick(tick)
  );

  scl_tmr_ucnt #(.UW(UW)) u_ucnt (
    .clk(clk), .rst_n(rst_s_n), .clear(restart), .tick(tick), .units(units)
  );

  // phase targets in units
  logic [UW-1:0] low_tgt, dly_tgt, rel_tgt, high_tgt, hold_tgt;
  assign low_tgt  = UW'(low_cnt) + UW'(1);
  assign dly_tgt  = UW'(hold_dly) + UW'(setup_dly) + UW'(1);
  assign rel_tgt  = (low_tgt > dly_tgt) ? low_tgt : dly_tgt;
  assign high_tgt = UW'(high_cnt) + UW'(1);
  assign hold_tgt = UW'(hold_dly);

  phase_e state_q, state_d;
  logic   bit_q, bit_d;
  logic   scl_q, scl_d;
  logic   sda_q, sda_d;
  logic   smp_q, smp_d;
  logic   done_q, done_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    smp_d   = 1'b0;
    done_d  = 1'b0;
    restart = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (bit_req) begin
          state_d = PH_LOW;
          bit_d   = bit_val;
          scl_d   = 1'b1;
          restart = 1'b1;
        end
      end
      PH_LOW: begin
        if (units == hold_tgt) sda_d = !bit_q;
        if (units >= rel_tgt) begin
          scl_d   = 1'b0;
          state_d = PH_RISE;
        end
      end
      PH_RISE: begin
        // high count waits until the line is really high
        if (scl_s) begin
          state_d = PH_HIGH;
          smp_d   = 1'b1;
          restart = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!scl_s || (units >= high_tgt)) begin
          state_d = PH_IDLE;
          scl_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= PH_IDLE;
      bit_q   <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      smp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      smp_q   <= smp_d;
      done_q  <= done_d;
    end
  end

  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign bit_sample = smp_q;
  assign bit_done   = done_q;

  // R5: the sample point lies inside a released stretch of SCL
  p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_sample |-> (!scl_oe && $past(!scl_oe)));

  // R6: a bit ends only after SCL was released
  p_done_after_high_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_done |-> $past(!scl_oe));

  // R7: a low seen on the line in the high phase ends the bit next cycle
  p_fall_ends_bit_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == PH_HIGH && !scl_s) |=> (bit_done && scl_oe));

  // R10: SDA is quiet while SCL is released
  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R5/R6: the two strobes never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({bit_sample, bit_done}));
endmodule

// File: tb/scl_bit_timer_bench.sv
`timescale 1ns/1ps
module scl_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] presc = '0;
  logic [7:0] low_cnt = '0;
  logic [7:0] high_cnt = '0;
  logic [3:0] hold_dly = '0;
  logic [3:0] setup_dly = '0;
  logic       bit_req = 1'b0;
  logic       bit_val = 1'b0;
  logic       scl_oe, sda_oe, bit_sample, bit_done;
  logic       stretch_pull = 1'b0;
  logic       mm_pull = 1'b0;
  wire        scl_line = !(scl_oe || stretch_pull || mm_pull);

  always #4 clk = !clk;

  scl_bit_timer u_scl_bit_timer (
    .clk(clk), .rst_n(rst_n), .presc(presc), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .hold_dly(hold_dly), .setup_dly(setup_dly),
    .bit_req(bit_req), .bit_val(bit_val), .scl_in(scl_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bit_sample(bit_sample), .bit_done(bit_done)
  );

  typedef struct {
    int bitv;
    int sda_dt;
    int rel_dt;
    int smp_dt;
    int done_dt;
  } exp_t;

  exp_t exp_q[$];
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  int   done_cnt = 0;
  int   smp_cnt = 0;
  int   stretch_n = 0;
  int   early_f = 0;
  int   sda_model = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // monitor and line agent: one process, samples after the falling edge
  initial begin
    bit mon_act = 1'b0;
    int t0 = 0, t_sda = -1, t_rel = -1, t_smp = -1;
    int prev_sda = 0, rem_s = 0, rem_f = 0;
    bit sda_moved_high = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (!mon_act) begin
        if (bit_sample || bit_done)
          chk(1'b0, "R8 stray strobe", int'(bit_sample) + int'(bit_done), 0);
        if (bit_req && rst_n) begin
          mon_act = 1'b1; t0 = cyc; t_sda = -1; t_rel = -1; t_smp = -1;
          prev_sda = int'(sda_oe); sda_moved_high = 1'b0;
        end
      end else begin
        if (t_rel < 0 && t_sda < 0 && int'(sda_oe) != prev_sda) t_sda = cyc;
        if (t_rel >= 0 && !scl_oe && int'(sda_oe) != prev_sda && t_sda >= 0)
          sda_moved_high = 1'b1;
        if (t_rel >= 0 && rem_s > 0) begin
          rem_s--;
          if (rem_s == 0) stretch_pull = 1'b0;
        end
        if (t_smp >= 0 && rem_f > 0 && !bit_done) begin
          rem_f--;
          if (rem_f == 0) mm_pull = 1'b1;
        end
        if (t_rel < 0 && !scl_oe) begin
          t_rel = cyc;
          rem_s = stretch_n;
          if (t_sda >= 0) prev_sda = int'(sda_oe);
        end
        if (bit_sample) begin
          t_smp = cyc; smp_cnt++;
          rem_f = early_f;
        end
        if (bit_done) begin
          mm_pull = 1'b0;
          done_cnt++;
          mon_act = 1'b0;
          e = exp_q.pop_front();
          chk((t_sda < 0 ? -1 : t_sda - t0) == e.sda_dt, "R3 hold delay",
              (t_sda < 0 ? -1 : t_sda - t0), e.sda_dt);
          chk(int'(sda_oe) == (e.bitv == 0 ? 1 : 0), "R3 data value",
              int'(sda_oe), (e.bitv == 0 ? 1 : 0));
          chk(t_rel - t0 == e.rel_dt, "R4/R2 low release", t_rel - t0, e.rel_dt);
          chk(t_smp - t_rel == e.smp_dt, "R5 sample after rise", t_smp - t_rel, e.smp_dt);
          chk(cyc - t_smp == e.done_dt, "R6/R7 bit end", cyc - t_smp, e.done_dt);
          chk(scl_oe == 1'b1, "R6 scl low at done", int'(scl_oe), 1);
          chk(!sda_moved_high, "R10 sda quiet while scl high", int'(sda_moved_high), 0);
        end
      end
    end
  end

  task automatic run_bit(input int p, input int l, input int h, input int hd, input int su,
                         input int bv, input int s, input int f, input bit spur);
    exp_t e;
    int rel, dc;
    @(negedge clk);
    presc = 4'(p); low_cnt = 8'(l); high_cnt = 8'(h);
    hold_dly = 4'(hd); setup_dly = 4'(su);
    rel = (l + 1 > hd + su + 1) ? l + 1 : hd + su + 1;
    e.bitv    = bv;
    e.sda_dt  = (sda_model != (bv == 0 ? 1 : 0)) ? hd * (p + 1) + 2 : -1;
    e.rel_dt  = rel * (p + 1) + 2;
    e.smp_dt  = s + 3;
    e.done_dt = (f > 0) ? f + 3 : (h + 1) * (p + 1) + 1;
    sda_model = (bv == 0) ? 1 : 0;
    exp_q.push_back(e);
    stretch_n = s; stretch_pull = (s > 0); early_f = f;
    dc = done_cnt;
    @(negedge clk);
    bit_req = 1'b1; bit_val = bv[0];
    @(negedge clk);
    bit_req = 1'b0;
    if (spur) begin
      repeat (3) @(negedge clk);
      bit_req = 1'b1; bit_val = !bv[0];
      @(negedge clk);
      bit_req = 1'b0;
    end
    while (done_cnt == dc) @(negedge clk);
  endtask

  // idle hold: no request, SCL stays low and SDA keeps the last bit
  task automatic idle_check(input string tag);
    int dc, sc;
    dc = done_cnt; sc = smp_cnt;
    repeat (30) @(negedge clk);
    #2;
    chk(scl_oe == 1'b1, {tag, " scl held low"}, int'(scl_oe), 1);
    chk(int'(sda_oe) == sda_model, {tag, " sda held"}, int'(sda_oe), sda_model);
    chk(done_cnt == dc && smp_cnt == sc, {tag, " no extra bit"}, done_cnt - dc, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #2;
    chk(scl_oe == 1'b0, "R1 scl_oe reset", int'(scl_oe), 0);
    chk(sda_oe == 1'b0, "R1 sda_oe reset", int'(sda_oe), 0);
    chk(!bit_sample && !bit_done, "R1 strobes reset", int'(bit_sample) + int'(bit_done), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #2;
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 released after reset", int'(scl_oe), 0);
    // R4 low count dominates, R2 presc 0
    run_bit(0, 3, 2, 1, 1, 0, 0, 0, 1'b0);
    // R4 hold+setup dominates, R2 presc 1
    run_bit(1, 2, 3, 2, 4, 1, 0, 0, 1'b0);
    // R3 repeated value, R5 stretch of 6 clocks, R2 presc 3
    run_bit(3, 5, 1, 0, 0, 1, 6, 0, 1'b0);
    // R7 other master pulls SCL low 4 clocks into the high count
    run_bit(2, 4, 6, 3, 2, 0, 0, 4, 1'b0);
    // R8 second request while busy
    run_bit(0, 1, 1, 0, 0, 1, 0, 0, 1'b1);
    idle_check("R8/R9");
    // R2 largest prescaler with longest delays
    run_bit(15, 2, 2, 15, 15, 0, 0, 0, 1'b0);
    // R4 long low count
    run_bit(0, 200, 9, 5, 3, 1, 2, 0, 1'b0);
    idle_check("R9");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule